// File: doc/BRIEF.md
# Hardware Transaction Nesting and Abort Controller

This block tracks one hardware thread's memory transaction. An instruction decoder sends it four commands: open, close, explicit abort and in-transaction query. Three event lines also feed it. They report a conflict from another thread against this thread's accessed lines, an interrupt, and an attempt to run an operation that cannot be undone. The block keeps a nesting depth and answers queries. When a transaction finishes it sends a one-cycle commit pulse. When a transaction is abandoned it sends a one-cycle abort pulse together with a cause/status word and the handler address.

Nested transactions are folded into the outermost one. Only the outermost open records a handler address. Only the close that returns the depth to zero commits. Any abort, at any depth, throws away the whole nest.

All outputs are registered. A command or event sampled at a rising edge produces its pulse, its query answer and its new depth in the cycle that follows that edge.

Top module: `txn_nest_ctrl`

## Requirements
- R1: An open command (op 0) raises `depth_o` by one. A close command (op 1) at nonzero depth lowers it by one. A close at depth zero changes nothing.
- R2: `commit_o` pulses for one cycle only after a close taken at depth 1. Closes at deeper levels produce no commit.
- R3: On every abort, `abort_target_o` equals the target given with the open taken at depth 0. Targets given with inner opens are ignored. The depth returns to 0 in the cycle of the pulse.
- R4: An explicit abort command (op 2) at nonzero depth aborts with status bit 0 set and its 8-bit code in status bits [31:24]. At depth 0 it is a no-op.
- R5: A query command (op 3) raises `test_valid_o` in the next cycle. With it, `test_in_txn_o` is 1 if the depth was nonzero when the query was taken, and 0 otherwise.
- R6: `irq_i` at nonzero depth aborts with status bit 2.
- R7: `restrict_i` at nonzero depth aborts with status bit 3.
- R8: `conflict_i` at nonzero depth aborts with status bit 1.
- R9: An open at depth 15 does not wrap. It aborts with status bit 4.
- R10: Event inputs seen at depth 0 are ignored. An open in the same cycle still proceeds.
- R11: When causes collide, an abort beats a close, so no commit is issued. Among abort causes the order is conflict, interrupt, restricted, explicit, overflow.
- R12: Every abort status word has exactly one cause bit set in [4:0]. The code field [31:24] is zero unless the cause is explicit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | 0 open, 1 close, 2 explicit abort, 3 query |
| cmd_target_i | input | TGT_W | Handler address carried by an open |
| cmd_code_i | input | CODE_W | Code carried by an explicit abort |
| conflict_i | input | 1 | Conflict from another thread |
| irq_i | input | 1 | Interrupt pending |
| restrict_i | input | 1 | Restricted operation attempted |
| depth_o | output | DEPTH_W | Current nesting depth |
| commit_o | output | 1 | Commit pulse |
| abort_o | output | 1 | Abort pulse |
| abort_status_o | output | STAT_W | Cause bits and explicit code |
| abort_target_o | output | TGT_W | Outermost handler address |
| test_valid_o | output | 1 | Query answer strobe |
| test_in_txn_o | output | 1 | Query answer: in transaction |

## Verification
The bench goes after the boundary cases where a careless design would go wrong:
- Inner closes: a design that commits on every close would send early commit pulses.
- Inner handler addresses: a design that latches the latest open would report an inner handler on abort.
- The sixteenth open: a design with a wrapping counter would silently return to depth 0 instead of aborting with the overflow cause.
- Same-cycle collisions: a close with a conflict, several causes together, and events at depth 0. A design with the wrong priority would commit an aborted transaction, report the wrong cause bit or leak an explicit code. A design that does not gate events by depth would abort with no transaction open.

// File: rtl/txn_pkg.sv
package txn_pkg;
  typedef enum logic [1:0] {
    OP_BEGIN = 2'd0,
    OP_END   = 2'd1,
    OP_ABORT = 2'd2,
    OP_TEST  = 2'd3
  } txn_op_e;

  localparam int unsigned CAUSE_N = 5;
  localparam int unsigned C_EXPL  = 0;
  localparam int unsigned C_CONF  = 1;
  localparam int unsigned C_IRQ   = 2;
  localparam int unsigned C_RESTR = 3;
  localparam int unsigned C_OVF   = 4;
endpackage

// File: rtl/txn_depth_ctr.sv
module txn_depth_ctr #(
  parameter int unsigned DEPTH_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               inc_i,
  input  logic               dec_i,
  input  logic               clr_i,
  output logic [DEPTH_W-1:0] depth_o,
  output logic               active_o,
  output logic               at_max_o,
  output logic               at_one_o
);
  localparam logic [DEPTH_W-1:0] MAX = {DEPTH_W{1'b1}};
  localparam logic [DEPTH_W-1:0] ONE = DEPTH_W'(1);

  logic [DEPTH_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + ONE;
    else if (dec_i) cnt_q <= cnt_q - ONE;
  end

  assign depth_o  = cnt_q;
  assign active_o = (cnt_q != '0);
  assign at_max_o = (cnt_q == MAX);
  assign at_one_o = (cnt_q == ONE);
endmodule

// File: rtl/txn_abort_arb.sv
module txn_abort_arb
  import txn_pkg::*;
#(
  parameter int unsigned STAT_W = 32,
  parameter int unsigned CODE_W = 8
) (
  input  logic [CAUSE_N-1:0] req_i,
  input  logic [CODE_W-1:0]  code_i,
  output logic               any_o,
  output logic [STAT_W-1:0]  status_o
);
  localparam int unsigned CODE_LSB = STAT_W - CODE_W;
  // highest priority first
  localparam int unsigned PRIO [CAUSE_N] = '{C_CONF, C_IRQ, C_RESTR, C_EXPL, C_OVF};

  logic [CAUSE_N-1:0] grant;

  always_comb begin
    grant = '0;
    for (int k = CAUSE_N - 1; k >= 0; k--) begin
      if (req_i[PRIO[k]]) begin
        grant = '0;
        grant[PRIO[k]] = 1'b1;
      end
    end
  end

  always_comb begin
    status_o = '0;
    status_o[CAUSE_N-1:0] = grant;
    status_o[CODE_LSB +: CODE_W] = grant[C_EXPL] ? code_i : '0;
  end

  assign any_o = |req_i;
endmodule

// File: rtl/txn_nest_ctrl.sv
module txn_nest_ctrl
  import txn_pkg::*;
#(
  parameter int unsigned DEPTH_W = 4,
  parameter int unsigned TGT_W   = 32,
  parameter int unsigned CODE_W  = 8,
  parameter int unsigned STAT_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  input  logic [1:0]         cmd_op_i,
  input  logic [TGT_W-1:0]   cmd_target_i,
  input  logic [CODE_W-1:0]  cmd_code_i,
  input  logic               conflict_i,
  input  logic               irq_i,
  input  logic               restrict_i,
  output logic [DEPTH_W-1:0] depth_o,
  output logic               commit_o,
  output logic               abort_o,
  output logic [STAT_W-1:0]  abort_status_o,
  output logic [TGT_W-1:0]   abort_target_o,
  output logic               test_valid_o,
  output logic               test_in_txn_o
);
  logic active, at_max, at_one;
  logic is_begin, is_end, is_abort, is_test;
  logic abort_now, commit_now;
  logic [CAUSE_N-1:0] cause_req;
  logic [STAT_W-1:0]  status_d;
  logic [TGT_W-1:0]   target_q;

  assign is_begin = cmd_valid_i && (cmd_op_i == OP_BEGIN);
  assign is_end   = cmd_valid_i && (cmd_op_i == OP_END);
  assign is_abort = cmd_valid_i && (cmd_op_i == OP_ABORT);
  assign is_test  = cmd_valid_i && (cmd_op_i == OP_TEST);

  // every cause is gated by an open transaction
  always_comb begin
    cause_req          = '0;
    cause_req[C_CONF]  = active && conflict_i;
    cause_req[C_IRQ]   = active && irq_i;
    cause_req[C_RESTR] = active && restrict_i;
    cause_req[C_EXPL]  = active && is_abort;
    cause_req[C_OVF]   = active && is_begin && at_max;
  end

  txn_abort_arb #(
    .STAT_W (STAT_W),
    .CODE_W (CODE_W)
  ) u_arb (
    .req_i    (cause_req),
    .code_i   (cmd_code_i),
    .any_o    (abort_now),
    .status_o (status_d)
  );

  assign commit_now = !abort_now && is_end && at_one;

  txn_depth_ctr #(
    .DEPTH_W (DEPTH_W)
  ) u_depth (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (is_begin && !abort_now),
    .dec_i    (is_end && active && !abort_now),
    .clr_i    (abort_now || commit_now),
    .depth_o  (depth_o),
    .active_o (active),
    .at_max_o (at_max),
    .at_one_o (at_one)
  );

  // only the outermost open records the handler
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  target_q <= '0;
    else if (is_begin && !active) target_q <= cmd_target_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      commit_o       <= 1'b0;
      abort_o        <= 1'b0;
      abort_status_o <= '0;
      abort_target_o <= '0;
      test_valid_o   <= 1'b0;
      test_in_txn_o  <= 1'b0;
    end else begin
      commit_o      <= commit_now;
      abort_o       <= abort_now;
      test_valid_o  <= is_test;
      test_in_txn_o <= is_test && active;
      if (abort_now) begin
        abort_status_o <= status_d;
        abort_target_o <= target_q;
      end
    end
  end
endmodule

// File: rtl/txn_nest_ctrl_chk.sv
module txn_nest_ctrl_chk
  import txn_pkg::*;
#(
  parameter int unsigned DEPTH_W = 4,
  parameter int unsigned TGT_W   = 32,
  parameter int unsigned CODE_W  = 8,
  parameter int unsigned STAT_W  = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cmd_valid_i,
  input logic [1:0]         cmd_op_i,
  input logic               conflict_i,
  input logic               irq_i,
  input logic               restrict_i,
  input logic [DEPTH_W-1:0] depth_o,
  input logic               commit_o,
  input logic               abort_o,
  input logic [STAT_W-1:0]  abort_status_o,
  input logic               test_valid_o,
  input logic               test_in_txn_o
);
  localparam logic [DEPTH_W-1:0] MAX = {DEPTH_W{1'b1}};
  localparam int unsigned CODE_LSB = STAT_W - CODE_W;

  logic quiet;
  assign quiet = !conflict_i && !irq_i && !restrict_i;

  AST_BEGIN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_BEGIN && depth_o != MAX && quiet)
    |=> depth_o == $past(depth_o) + DEPTH_W'(1)); // R1

  AST_COMMIT_OUTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> ($past(depth_o) == DEPTH_W'(1)) && depth_o == '0); // R2

  AST_ABORT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> depth_o == '0); // R3

  AST_IDLE_NO_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (depth_o == '0) |=> !abort_o); // R10

  AST_TEST_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_valid_o |-> test_in_txn_o == ($past(depth_o) != '0)); // R5

  AST_NO_DOUBLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit_o && abort_o)); // R11

  AST_ONE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $countones(abort_status_o[CAUSE_N-1:0]) == 1); // R12

  AST_CODE_ONLY_EXPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_o && !abort_status_o[C_EXPL]) |-> abort_status_o[CODE_LSB +: CODE_W] == '0); // R12

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_BEGIN && depth_o == MAX)
    |=> abort_o && depth_o == '0); // R9
endmodule

bind txn_nest_ctrl txn_nest_ctrl_chk #(
  .DEPTH_W (DEPTH_W),
  .TGT_W   (TGT_W),
  .CODE_W  (CODE_W),
  .STAT_W  (STAT_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cmd_valid_i    (cmd_valid_i),
  .cmd_op_i       (cmd_op_i),
  .conflict_i     (conflict_i),
  .irq_i          (irq_i),
  .restrict_i     (restrict_i),
  .depth_o        (depth_o),
  .commit_o       (commit_o),
  .abort_o        (abort_o),
  .abort_status_o (abort_status_o),
  .test_valid_o   (test_valid_o),
  .test_in_txn_o  (test_in_txn_o)
);

// File: tb/txn_nest_ctrl_test.sv
module txn_nest_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [31:0] cmd_target = '0;
  logic [7:0]  cmd_code = '0;
  logic        conflict = 1'b0, irq = 1'b0, restr = 1'b0;
  logic [3:0]  depth;
  logic        commit, abort_p, test_v, test_f;
  logic [31:0] status, target;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  txn_nest_ctrl uut (
    .clk_i (clk), .rst_ni (rst_n),
    .cmd_valid_i (cmd_valid), .cmd_op_i (cmd_op),
    .cmd_target_i (cmd_target), .cmd_code_i (cmd_code),
    .conflict_i (conflict), .irq_i (irq), .restrict_i (restr),
    .depth_o (depth), .commit_o (commit), .abort_o (abort_p),
    .abort_status_o (status), .abort_target_o (target),
    .test_valid_o (test_v), .test_in_txn_o (test_f)
  );

  typedef struct {
    bit          commit;
    bit          abort_p;
    logic [31:0] status;
    logic [31:0] target;
    bit          test_v;
    bit          flag;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   m_depth = 0;
  logic [31:0] m_tgt = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: builds expectation from the requirements, then drives one cycle
  task automatic step(input bit v, input logic [1:0] op, input logic [31:0] tgt,
                      input logic [7:0] code, input bit c, input bit i, input bit r,
                      input string tag);
    exp_t e;
    bit act, is_b, is_e, xab, ovf, ab, cm;
    act  = (m_depth != 0);
    is_b = v && op == 2'd0;
    is_e = v && op == 2'd1;
    xab  = act && v && op == 2'd2;
    ovf  = act && is_b && m_depth == 15;
    ab   = (act && (c || i || r)) || xab || ovf;
    cm   = !ab && is_e && m_depth == 1;
    e.commit = cm; e.abort_p = ab; e.target = m_tgt;
    e.test_v = v && op == 2'd3; e.flag = act; e.tag = tag;
    if (act && c)      e.status = 32'h2;
    else if (act && i) e.status = 32'h4;
    else if (act && r) e.status = 32'h8;
    else if (xab)      e.status = {code, 24'h1};
    else               e.status = 32'h10;
    if (is_b && !act) m_tgt = tgt;
    if (ab || cm)           m_depth = 0;
    else if (is_b)          m_depth++;
    else if (is_e && act)   m_depth--;
    sb.push_back(e);
    cmd_valid = v; cmd_op = op; cmd_target = tgt; cmd_code = code;
    conflict = c; irq = i; restr = r;
    @(posedge clk); #2;
    chk(depth == 4'(m_depth), tag, "depth", 32'(depth), 32'(m_depth));
    @(negedge clk);
    cmd_valid = 0; conflict = 0; irq = 0; restr = 0;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk); #2;
      if (rst_n) begin
        if (sb.size() != 0) begin
          exp_t e;
          e = sb.pop_front();
          chk(commit == e.commit, e.tag, "commit", 32'(commit), 32'(e.commit));
          chk(abort_p == e.abort_p, e.tag, "abort", 32'(abort_p), 32'(e.abort_p));
          if (e.abort_p) begin
            chk(status == e.status, e.tag, "status", status, e.status);
            chk(target == e.target, e.tag, "target", target, e.target);
          end
          chk(test_v == e.test_v, e.tag, "test_valid", 32'(test_v), 32'(e.test_v));
          if (e.test_v)
            chk(test_f == e.flag, e.tag, "test_flag", 32'(test_f), 32'(e.flag));
        end else begin
          chk(!(commit || abort_p || test_v), "idle", "spurious pulse",
              {29'd0, commit, abort_p, test_v}, 32'd0);
        end
      end
    end
  end

  task automatic op_b(input logic [31:0] t, input string tag);
    step(1, 2'd0, t, 8'h0, 0, 0, 0, tag);
  endtask
  task automatic op_e(input string tag);
    step(1, 2'd1, 32'h0, 8'h0, 0, 0, 0, tag);
  endtask
  task automatic op_t(input string tag);
    step(1, 2'd3, 32'h0, 8'h0, 0, 0, 0, tag);
  endtask
  task automatic ev(input bit c, input bit i, input bit r, input string tag);
    step(0, 2'd0, 32'h0, 8'h0, c, i, r, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({depth, commit, abort_p, test_v} == '0, "reset", "outputs",
        {25'd0, depth, commit, abort_p, test_v}, 32'd0);
    rst_n = 1;
    @(negedge clk);

    // R1 R2 R5: nesting, inner close, query
    op_b(32'h100, "R1_open");
    op_b(32'h200, "R1_inner");
    op_t("R5_in");
    op_e("R2_inner_close");
    op_e("R2_commit");
    op_t("R5_out");
    op_e("R1_close_at_zero");

    // R3 R4: explicit abort at depth 2 reports outer target and code
    op_b(32'h300, "R3_open");
    op_b(32'h400, "R3_inner");
    step(1, 2'd2, 32'h0, 8'hA5, 0, 0, 0, "R4_explicit");
    step(1, 2'd2, 32'h0, 8'h5A, 0, 0, 0, "R4_explicit_idle");

    // R10: events at depth 0 ignored
    ev(1, 1, 1, "R10_events_idle");
    step(1, 2'd0, 32'h500, 8'h0, 1, 0, 0, "R10_open_with_conflict");
    op_e("R10_commit");

    // R6 R7 R8
    op_b(32'h600, "R6_open");  ev(0, 1, 0, "R6_irq");
    op_b(32'h700, "R7_open");  ev(0, 0, 1, "R7_restrict");
    op_b(32'h800, "R8_open");  op_b(32'h880, "R8_inner");
    ev(1, 0, 0, "R8_conflict");

    // R11: abort beats close; priority among causes
    op_b(32'h900, "R11_open");
    step(1, 2'd1, 32'h0, 8'h0, 1, 0, 0, "R11_close_vs_conflict");
    op_b(32'hA00, "R11_open2");
    step(1, 2'd2, 32'h0, 8'h77, 1, 1, 1, "R11_all_causes");
    op_b(32'hB00, "R11_open3");
    step(1, 2'd2, 32'h0, 8'h33, 0, 1, 1, "R11_irq_first");
    op_b(32'hB80, "R12_open");
    step(1, 2'd3, 32'h0, 8'h0, 0, 0, 1, "R12_query_with_abort");

    // R9: overflow at depth 15
    op_b(32'hC00, "R9_open");
    for (int k = 0; k < 14; k++) op_b(32'hD00 + 32'(k), "R9_fill");
    op_b(32'hE00, "R9_overflow");
    op_t("R9_after");

    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "end", "scoreboard drained", 32'(sb.size()), 32'd0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule